// File: doc/BRIEF.md
# Speculative load cache access gate

This block is the front of a small set-associative L1 data store. It stands between the load pipeline and the tag, data and pseudo-LRU arrays, and it keeps loads that are still speculative from leaving any trace outside the core. Each request carries a shadow flag that says whether the load can still be squashed. A load without the flag is a plain cache access. A load with the flag may read a line that is already present. Its replacement update and prefetch hint are parked in a small buffer until the pipeline sends a release for that load-queue index. A shadowed load that misses never produces a request to the next level.

A small table of last-seen load values is read in parallel with the tags. A shadowed miss whose table entry has reached the confidence threshold gets the stored value back in the same response cycle, marked as predicted. The table learns only from data that can no longer be squashed. One prediction can be pending at a time. When the predicted load reissues without its shadow, it takes the normal miss path. The returning fill is then compared with the guess, and a mismatch raises a mispredict flag carrying the load index. A squash input drops deferred updates and the pending prediction for loads younger than a given index.

Top module: `spec_load_gate`

## Requirements
- R1: An unshadowed request that hits gives, one cycle later, a response with hit=1 and the line data, a prefetch pulse (pf_valid) with the request address, and a replacement update that marks the way as used.
- R2: An unshadowed request that misses gives, one cycle later, a response with hit=0 and pred=0, and a next-level request (miss_valid) with the address.
- R3: A shadowed request that hits returns hit=1 and the line data, but raises no pf_valid and leaves the pseudo-LRU state unchanged, so a later fill still evicts the way it would have evicted anyway.
- R4: A shadowed request that misses never raises miss_valid, and it returns hit=0.
- R5: A release names a load-queue index. If a parked entry holds that index, the block applies its replacement update and pulses pf_rel_valid with the entry's address one cycle later. A release that matches no entry has no effect.
- R6: A squash removes every parked entry whose load-queue index is numerically greater than the squash index. Entries with an equal or smaller index stay and can still be released.
- R7: When all DQ_DEPTH parked slots are in use, a shadowed hit is reported as hit=0 with no data, and nothing is parked.
- R8: The value table is indexed by the low tag bits and trained by unshadowed hits and by fills. A new address or a new value resets the entry's count to 0, and each repeat adds 1. A shadowed miss whose entry matches the full address with a count of at least CONF_TH returns pred=1 and the stored value, with no extra latency.
- R9: While a prediction is pending, no other request gets pred=1.
- R10: The predicted load reissues unshadowed with the same index and goes out as a normal miss. The fill to that address is compared with the guess. A difference pulses mispredict_valid with the load index one cycle after the fill. Equal data raises nothing.
- R11: After reset, no output valid is high and every line is invalid, so the first unshadowed access misses.
- R12: A fill installs its line into the tree pseudo-LRU victim way of its set and counts as a use of that way. From reset, four fills to one set take ways 0, 2, 1 and 3, in that order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Load request present |
| req_addr | input | ADDR_W | Line address, tag above set bits |
| req_shadow | input | 1 | Load is still speculative |
| req_lqid | input | LQ_W | Load-queue index of the request |
| rsp_valid | output | 1 | Response present |
| rsp_lqid | output | LQ_W | Index of the answered load |
| rsp_hit | output | 1 | Data came from the cache |
| rsp_pred | output | 1 | Data is a predicted value |
| rsp_data | output | DATA_W | Returned data |
| miss_valid | output | 1 | Request to the next level |
| miss_addr | output | ADDR_W | Address of that request |
| fill_valid | input | 1 | Line returning from the next level |
| fill_addr | input | ADDR_W | Address of the returning line |
| fill_data | input | DATA_W | Data of the returning line |
| rel_valid | input | 1 | Load has left its shadow |
| rel_lqid | input | LQ_W | Index of the released load |
| sq_valid | input | 1 | Squash request |
| sq_lqid | input | LQ_W | Loads with a larger index are squashed |
| pf_valid | output | 1 | Prefetch hint from an unshadowed hit |
| pf_addr | output | ADDR_W | Address of that hint |
| pf_rel_valid | output | 1 | Prefetch hint from a released hit |
| pf_rel_addr | output | ADDR_W | Address of that hint |
| mispredict_valid | output | 1 | Validation found a wrong guess |
| mispredict_lqid | output | LQ_W | Index of the mispredicted load |

## Verification
One set is filled with four lines and then reached through three kinds of access: an unshadowed hit, a shadowed hit left parked, and a shadowed hit that is later released or squashed. A fifth fill follows, and probing which old line it displaced separates a replacement update that was applied from one that was held back. Releases with an unknown index and squashes that straddle two parked entries separate index matching from blanket clearing. The buffer is filled to capacity to show how a shadowed hit degrades. The value path is trained up to the threshold and then driven through a second shadowed miss, a reissue and a fill with matching and with differing data, which separates a correct guess, a blocked second guess and a mispredict.

// File: rtl/slg_pkg.sv
package slg_pkg;
  // life of the single pending value prediction
  typedef enum logic [1:0] {
    PS_IDLE = 2'd0,  // no guess outstanding
    PS_WAIT = 2'd1,  // guess handed out, load still shadowed
    PS_VAL  = 2'd2   // reissued unshadowed, fill awaited
  } pred_st_e;
endpackage

// File: rtl/slg_tag_store.sv
module slg_tag_store #(
  parameter int SETS   = 4,
  parameter int WAYS   = 4,
  parameter int TAG_W  = 6,
  parameter int DATA_W = 16
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [$clog2(SETS)-1:0]    lk_set,
  input  logic [TAG_W-1:0]           lk_tag,
  output logic                       lk_hit,
  output logic [$clog2(WAYS)-1:0]    lk_way,
  output logic [DATA_W-1:0]          lk_data,
  input  logic                       fill_en,
  input  logic [$clog2(SETS)-1:0]    fill_set,
  input  logic [TAG_W-1:0]           fill_tag,
  input  logic [DATA_W-1:0]          fill_data,
  input  logic                       t0_en,
  input  logic [$clog2(SETS)-1:0]    t0_set,
  input  logic [$clog2(WAYS)-1:0]    t0_way,
  input  logic                       t1_en,
  input  logic [$clog2(SETS)-1:0]    t1_set,
  input  logic [$clog2(WAYS)-1:0]    t1_way
);
  localparam int SET_W = $clog2(SETS);
  localparam int WAY_W = $clog2(WAYS);
  localparam int NODES = WAYS - 1;

  logic [TAG_W-1:0]  tag_q  [SETS][WAYS];
  logic [DATA_W-1:0] dat_q  [SETS][WAYS];
  logic [WAYS-1:0]   vld_q  [SETS];
  logic [NODES-1:0]  plru_q [SETS];
  logic [NODES-1:0]  plru_d [SETS];
  logic [WAY_W-1:0]  fill_way;

  // walk the tree from the root following the stored bits
  function automatic logic [WAY_W-1:0] pick_victim(input logic [NODES-1:0] b);
    int unsigned n;
    n = 1;
    for (int l = 0; l < WAY_W; l++) begin
      if (b[n-1]) n = 2 * n + 1;
      else        n = 2 * n;
    end
    return WAY_W'(n - WAYS);
  endfunction

  // point every node on the path of way w away from it
  function automatic logic [NODES-1:0] touch(input logic [NODES-1:0] b,
                                             input logic [WAY_W-1:0] w);
    logic [NODES-1:0] r;
    int unsigned n;
    r = b;
    n = WAYS + 32'(w);
    for (int l = 0; l < WAY_W; l++) begin
      r[(n >> 1) - 1] = ~n[0];
      n = n >> 1;
    end
    return r;
  endfunction

  always_comb begin
    lk_hit  = 1'b0;
    lk_way  = '0;
    lk_data = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (!lk_hit && vld_q[lk_set][w] && tag_q[lk_set][w] == lk_tag) begin
        lk_hit  = 1'b1;
        lk_way  = WAY_W'(w);
        lk_data = dat_q[lk_set][w];
      end
    end
  end

  assign fill_way = pick_victim(plru_q[fill_set]);

  // fill, demand hit and release may all use one set in the same cycle
  always_comb begin
    for (int s = 0; s < SETS; s++) begin
      plru_d[s] = plru_q[s];
      if (fill_en && fill_set == SET_W'(s)) plru_d[s] = touch(plru_d[s], fill_way);
      if (t0_en && t0_set == SET_W'(s))     plru_d[s] = touch(plru_d[s], t0_way);
      if (t1_en && t1_set == SET_W'(s))     plru_d[s] = touch(plru_d[s], t1_way);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < SETS; s++) begin
        vld_q[s]  <= '0;
        plru_q[s] <= '0;
      end
    end else begin
      plru_q <= plru_d;
      if (fill_en) vld_q[fill_set][fill_way] <= 1'b1;
    end
  end

  // arrays without reset, one write port
  always_ff @(posedge clk) begin
    if (fill_en) begin
      tag_q[fill_set][fill_way] <= fill_tag;
      dat_q[fill_set][fill_way] <= fill_data;
    end
  end

  a_r12_fill_lands: assert property (@(posedge clk) disable iff (rst)
    fill_en |=> vld_q[$past(fill_set)][$past(fill_way)]);
endmodule

// File: rtl/slg_defer_q.sv
module slg_defer_q #(
  parameter int DEPTH  = 4,
  parameter int LQ_W   = 4,
  parameter int ADDR_W = 8,
  parameter int WAY_W  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              push,
  input  logic [LQ_W-1:0]   push_lqid,
  input  logic [ADDR_W-1:0] push_addr,
  input  logic [WAY_W-1:0]  push_way,
  output logic              full,
  input  logic              rel_en,
  input  logic [LQ_W-1:0]   rel_lqid,
  output logic              rel_hit,
  output logic [ADDR_W-1:0] rel_addr,
  output logic [WAY_W-1:0]  rel_way,
  input  logic              sq_en,
  input  logic [LQ_W-1:0]   sq_lqid
);
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [DEPTH-1:0]  v_q;
  logic [LQ_W-1:0]   lq_q [DEPTH];
  logic [ADDR_W-1:0] ad_q [DEPTH];
  logic [WAY_W-1:0]  wy_q [DEPTH];
  logic [IDX_W-1:0]  free_i, rel_i;
  logic              free_ok;

  assign full = &v_q;

  always_comb begin
    free_ok  = 1'b0;
    free_i   = '0;
    rel_hit  = 1'b0;
    rel_i    = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (!free_ok && !v_q[i]) begin
        free_ok = 1'b1;
        free_i  = IDX_W'(i);
      end
      if (!rel_hit && rel_en && v_q[i] && lq_q[i] == rel_lqid) begin
        rel_hit = 1'b1;
        rel_i   = IDX_W'(i);
      end
    end
    rel_addr = ad_q[rel_i];
    rel_way  = wy_q[rel_i];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      v_q <= '0;
    end else begin
      for (int i = 0; i < DEPTH; i++)
        if (sq_en && v_q[i] && lq_q[i] > sq_lqid) v_q[i] <= 1'b0;
      if (rel_hit) v_q[rel_i] <= 1'b0;
      if (push && free_ok) v_q[free_i] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (push && free_ok) begin
      lq_q[free_i] <= push_lqid;
      ad_q[free_i] <= push_addr;
      wy_q[free_i] <= push_way;
    end
  end

  a_r7_no_push_when_full: assert property (@(posedge clk) disable iff (rst)
    push |-> !full);
  a_r5_release_frees: assert property (@(posedge clk) disable iff (rst)
    rel_hit && !push |=> $countones(v_q) < $past($countones(v_q)));
endmodule

// File: rtl/slg_value_tab.sv
module slg_value_tab #(
  parameter int ENTRIES = 4,
  parameter int ADDR_W  = 8,
  parameter int DATA_W  = 16,
  parameter int IDX_LSB = 2,
  parameter int CONF_W  = 2,
  parameter int CONF_TH = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] lk_addr,
  output logic              lk_conf,
  output logic [DATA_W-1:0] lk_val,
  input  logic              tr_en,
  input  logic [ADDR_W-1:0] tr_addr,
  input  logic [DATA_W-1:0] tr_data
);
  localparam int IDX_W = $clog2(ENTRIES);

  logic [ENTRIES-1:0] v_q;
  logic [ADDR_W-1:0]  tg_q [ENTRIES];
  logic [DATA_W-1:0]  vl_q [ENTRIES];
  logic [CONF_W-1:0]  cf_q [ENTRIES];
  logic [IDX_W-1:0]   li, ti;
  logic               same;

  assign li      = lk_addr[IDX_LSB +: IDX_W];
  assign lk_conf = v_q[li] && tg_q[li] == lk_addr && cf_q[li] >= CONF_W'(CONF_TH);
  assign lk_val  = vl_q[li];

  assign ti   = tr_addr[IDX_LSB +: IDX_W];
  assign same = v_q[ti] && tg_q[ti] == tr_addr && vl_q[ti] == tr_data;

  always_ff @(posedge clk) begin
    if (rst) v_q <= '0;
    else if (tr_en) v_q[ti] <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (tr_en) begin
      if (same) begin
        if (cf_q[ti] != '1) cf_q[ti] <= cf_q[ti] + 1'b1;
      end else begin
        tg_q[ti] <= tr_addr;
        vl_q[ti] <= tr_data;
        cf_q[ti] <= '0;
      end
    end
  end

  a_r8_new_value_not_confident: assert property (@(posedge clk) disable iff (rst)
    tr_en && !same && lk_addr == tr_addr |=> !(lk_conf && lk_addr == $past(tr_addr)));
endmodule

// File: rtl/spec_load_gate.sv
module spec_load_gate #(
  parameter int SETS       = 4,
  parameter int WAYS       = 4,
  parameter int TAG_W      = 6,
  parameter int DATA_W     = 16,
  parameter int LQ_W       = 4,
  parameter int DQ_DEPTH   = 4,
  parameter int VT_ENTRIES = 4,
  parameter int CONF_W     = 2,
  parameter int CONF_TH    = 2
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          req_valid,
  input  logic [TAG_W+$clog2(SETS)-1:0] req_addr,
  input  logic                          req_shadow,
  input  logic [LQ_W-1:0]               req_lqid,
  output logic                          rsp_valid,
  output logic [LQ_W-1:0]               rsp_lqid,
  output logic                          rsp_hit,
  output logic                          rsp_pred,
  output logic [DATA_W-1:0]             rsp_data,
  output logic                          miss_valid,
  output logic [TAG_W+$clog2(SETS)-1:0] miss_addr,
  input  logic                          fill_valid,
  input  logic [TAG_W+$clog2(SETS)-1:0] fill_addr,
  input  logic [DATA_W-1:0]             fill_data,
  input  logic                          rel_valid,
  input  logic [LQ_W-1:0]               rel_lqid,
  input  logic                          sq_valid,
  input  logic [LQ_W-1:0]               sq_lqid,
  output logic                          pf_valid,
  output logic [TAG_W+$clog2(SETS)-1:0] pf_addr,
  output logic                          pf_rel_valid,
  output logic [TAG_W+$clog2(SETS)-1:0] pf_rel_addr,
  output logic                          mispredict_valid,
  output logic [LQ_W-1:0]               mispredict_lqid
);
  import slg_pkg::*;

  localparam int SET_W  = $clog2(SETS);
  localparam int WAY_W  = $clog2(WAYS);
  localparam int ADDR_W = TAG_W + SET_W;

  logic              ts_hit, dq_full, dq_rel_hit, vt_conf;
  logic [WAY_W-1:0]  ts_way, dq_rel_way;
  logic [DATA_W-1:0] ts_data, vt_val;
  logic [ADDR_W-1:0] dq_rel_addr;
  logic              demand_hit, park, shadow_missish, pred_ok;
  logic              chk;
  logic [DATA_W-1:0] chk_data;
  pred_st_e          ps_q, ps_d;
  logic [LQ_W-1:0]   ps_lqid_q;
  logic [ADDR_W-1:0] ps_addr_q;
  logic [DATA_W-1:0] ps_val_q;

  assign demand_hit     = req_valid && ts_hit && !req_shadow;
  assign park           = req_valid && ts_hit && req_shadow && !dq_full;
  assign shadow_missish = req_valid && req_shadow && (!ts_hit || dq_full);
  assign pred_ok        = shadow_missish && vt_conf && ps_q == PS_IDLE;

  slg_tag_store #(.SETS(SETS), .WAYS(WAYS), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_tags (
    .clk(clk), .rst(rst),
    .lk_set(req_addr[SET_W-1:0]), .lk_tag(req_addr[ADDR_W-1:SET_W]),
    .lk_hit(ts_hit), .lk_way(ts_way), .lk_data(ts_data),
    .fill_en(fill_valid), .fill_set(fill_addr[SET_W-1:0]),
    .fill_tag(fill_addr[ADDR_W-1:SET_W]), .fill_data(fill_data),
    .t0_en(demand_hit), .t0_set(req_addr[SET_W-1:0]), .t0_way(ts_way),
    .t1_en(dq_rel_hit), .t1_set(dq_rel_addr[SET_W-1:0]), .t1_way(dq_rel_way)
  );

  slg_defer_q #(.DEPTH(DQ_DEPTH), .LQ_W(LQ_W), .ADDR_W(ADDR_W), .WAY_W(WAY_W)) u_defer (
    .clk(clk), .rst(rst),
    .push(park), .push_lqid(req_lqid), .push_addr(req_addr), .push_way(ts_way),
    .full(dq_full),
    .rel_en(rel_valid), .rel_lqid(rel_lqid),
    .rel_hit(dq_rel_hit), .rel_addr(dq_rel_addr), .rel_way(dq_rel_way),
    .sq_en(sq_valid), .sq_lqid(sq_lqid)
  );

  slg_value_tab #(.ENTRIES(VT_ENTRIES), .ADDR_W(ADDR_W), .DATA_W(DATA_W),
                  .IDX_LSB(SET_W), .CONF_W(CONF_W), .CONF_TH(CONF_TH)) u_vtab (
    .clk(clk), .rst(rst),
    .lk_addr(req_addr), .lk_conf(vt_conf), .lk_val(vt_val),
    .tr_en(fill_valid || demand_hit),
    .tr_addr(fill_valid ? fill_addr : req_addr),
    .tr_data(fill_valid ? fill_data : ts_data)
  );

  // pending prediction: wait for the unshadowed reissue, then the fill
  always_comb begin
    ps_d     = ps_q;
    chk      = 1'b0;
    chk_data = '0;
    case (ps_q)
      PS_IDLE: if (pred_ok) ps_d = PS_WAIT;
      PS_WAIT: if (req_valid && !req_shadow && req_lqid == ps_lqid_q) begin
        if (ts_hit) begin
          chk      = 1'b1;
          chk_data = ts_data;
          ps_d     = PS_IDLE;
        end else begin
          ps_d = PS_VAL;
        end
      end
      PS_VAL: if (fill_valid && fill_addr == ps_addr_q) begin
        chk      = 1'b1;
        chk_data = fill_data;
        ps_d     = PS_IDLE;
      end
      default: ps_d = PS_IDLE;
    endcase
    if (sq_valid && ps_q != PS_IDLE && ps_lqid_q > sq_lqid) begin
      ps_d = PS_IDLE;
      chk  = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ps_q             <= PS_IDLE;
      rsp_valid        <= 1'b0;
      rsp_hit          <= 1'b0;
      rsp_pred         <= 1'b0;
      miss_valid       <= 1'b0;
      pf_valid         <= 1'b0;
      pf_rel_valid     <= 1'b0;
      mispredict_valid <= 1'b0;
    end else begin
      ps_q             <= ps_d;
      rsp_valid        <= req_valid;
      rsp_hit          <= req_valid && ts_hit && (!req_shadow || !dq_full);
      rsp_pred         <= pred_ok;
      miss_valid       <= req_valid && !ts_hit && !req_shadow;
      pf_valid         <= demand_hit;
      pf_rel_valid     <= dq_rel_hit;
      mispredict_valid <= chk && chk_data != ps_val_q;
    end
  end

  always_ff @(posedge clk) begin
    rsp_lqid        <= req_lqid;
    miss_addr       <= req_addr;
    pf_addr         <= req_addr;
    pf_rel_addr     <= dq_rel_addr;
    mispredict_lqid <= ps_lqid_q;
    if (demand_hit || park) rsp_data <= ts_data;
    else if (pred_ok)       rsp_data <= vt_val;
    else                    rsp_data <= '0;
    if (pred_ok) begin
      ps_lqid_q <= req_lqid;
      ps_addr_q <= req_addr;
      ps_val_q  <= vt_val;
    end
  end

  a_r1_rsp_each_req: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> rsp_valid && rsp_lqid == $past(req_lqid));
  a_r4_shadow_no_fill: assert property (@(posedge clk) disable iff (rst)
    req_valid && req_shadow |=> !miss_valid);
  a_r3_shadow_no_pf: assert property (@(posedge clk) disable iff (rst)
    req_valid && req_shadow |=> !pf_valid);
  a_r9_one_guess: assert property (@(posedge clk) disable iff (rst)
    req_valid && ps_q != PS_IDLE |=> !rsp_pred);
  a_r10_mispredict_from_slot: assert property (@(posedge clk) disable iff (rst)
    mispredict_valid |-> $past(ps_q) != PS_IDLE);
endmodule

// File: tb/spec_load_gate_tb_top.sv
module spec_load_gate_tb_top;
  localparam int AW = 8;
  localparam int DW = 16;
  localparam int LW = 4;

  logic clk = 1'b0, rst = 1'b1;
  logic req_valid = 0, req_shadow = 0;
  logic [AW-1:0] req_addr = 0;
  logic [LW-1:0] req_lqid = 0;
  logic rsp_valid, rsp_hit, rsp_pred, miss_valid, pf_valid, pf_rel_valid, mispredict_valid;
  logic [LW-1:0] rsp_lqid, mispredict_lqid;
  logic [DW-1:0] rsp_data;
  logic [AW-1:0] miss_addr, pf_addr, pf_rel_addr;
  logic fill_valid = 0, rel_valid = 0, sq_valid = 0;
  logic [AW-1:0] fill_addr = 0;
  logic [DW-1:0] fill_data = 0;
  logic [LW-1:0] rel_lqid = 0, sq_lqid = 0;

  spec_load_gate dut_i (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
    .req_shadow(req_shadow), .req_lqid(req_lqid), .rsp_valid(rsp_valid),
    .rsp_lqid(rsp_lqid), .rsp_hit(rsp_hit), .rsp_pred(rsp_pred), .rsp_data(rsp_data),
    .miss_valid(miss_valid), .miss_addr(miss_addr), .fill_valid(fill_valid),
    .fill_addr(fill_addr), .fill_data(fill_data), .rel_valid(rel_valid),
    .rel_lqid(rel_lqid), .sq_valid(sq_valid), .sq_lqid(sq_lqid),
    .pf_valid(pf_valid), .pf_addr(pf_addr), .pf_rel_valid(pf_rel_valid),
    .pf_rel_addr(pf_rel_addr), .mispredict_valid(mispredict_valid),
    .mispredict_lqid(mispredict_lqid)
  );

  always #5 clk = ~clk;

  // set 0 lines (tag 1..5), set 1 lines for the value path
  localparam logic [AW-1:0] LA = 8'h04, LB = 8'h08, LC = 8'h0C, LD = 8'h10, LE = 8'h14;
  localparam logic [AW-1:0] LP = 8'h05;

  typedef struct {
    logic [LW-1:0] lq;
    logic hit, pred, miss, pf;
    logic [DW-1:0] data;
    logic [AW-1:0] addr;
    string rq;
  } exp_t;

  exp_t exp_q[$];
  exp_t mon_e;
  int n_chk = 0, n_bad = 0;

  task automatic chk1(string rq, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", rq, act, exp);
    end
  endtask

  // scoreboard monitor, samples just after the edge
  always @(posedge clk) begin
    #1;
    if (!rst && rsp_valid) begin
      if (exp_q.size() == 0) chk1("R1 unexpected response", 32'd1, 32'd0);
      else begin
        mon_e = exp_q.pop_front();
        chk1({mon_e.rq, " lqid"}, 32'(rsp_lqid), 32'(mon_e.lq));
        chk1({mon_e.rq, " hit"},  32'(rsp_hit),  32'(mon_e.hit));
        chk1({mon_e.rq, " pred"}, 32'(rsp_pred), 32'(mon_e.pred));
        if (mon_e.hit || mon_e.pred) chk1({mon_e.rq, " data"}, 32'(rsp_data), 32'(mon_e.data));
        chk1({mon_e.rq, " miss"}, 32'(miss_valid), 32'(mon_e.miss));
        if (mon_e.miss) chk1({mon_e.rq, " miss addr"}, 32'(miss_addr), 32'(mon_e.addr));
        chk1({mon_e.rq, " pf"}, 32'(pf_valid), 32'(mon_e.pf));
        if (mon_e.pf) chk1({mon_e.rq, " pf addr"}, 32'(pf_addr), 32'(mon_e.addr));
      end
    end
  end

  task automatic ld(logic [AW-1:0] a, logic sh, logic [LW-1:0] lq, logic hit,
                    logic pred, logic [DW-1:0] d, logic miss, logic pf, string rq);
    exp_t e;
    e.lq = lq; e.hit = hit; e.pred = pred; e.data = d; e.miss = miss;
    e.pf = pf; e.addr = a; e.rq = rq;
    @(negedge clk);
    exp_q.push_back(e);
    req_valid = 1; req_addr = a; req_shadow = sh; req_lqid = lq;
    @(negedge clk);
    req_valid = 0;
  endtask

  task automatic fill(logic [AW-1:0] a, logic [DW-1:0] d);
    @(negedge clk);
    fill_valid = 1; fill_addr = a; fill_data = d;
    @(negedge clk);
    fill_valid = 0;
  endtask

  task automatic rel(logic [LW-1:0] lq, logic exp_v, logic [AW-1:0] exp_a, string rq);
    @(negedge clk);
    rel_valid = 1; rel_lqid = lq;
    @(negedge clk);
    rel_valid = 0;
    chk1({rq, " release pulse"}, 32'(pf_rel_valid), 32'(exp_v));
    if (exp_v) chk1({rq, " release addr"}, 32'(pf_rel_addr), 32'(exp_a));
  endtask

  task automatic squash(logic [LW-1:0] lq);
    @(negedge clk);
    sq_valid = 1; sq_lqid = lq;
    @(negedge clk);
    sq_valid = 0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1; req_valid = 0; fill_valid = 0; rel_valid = 0; sq_valid = 0;
    exp_q.delete();
    repeat (2) @(negedge clk);
    rst = 0;
  endtask

  task automatic fill4();
    fill(LA, 16'h1111); fill(LB, 16'h2222); fill(LC, 16'h3333); fill(LD, 16'h4444);
  endtask

  // train LP to confidence, then push it out of set 1
  task automatic vp_setup();
    fill(LP, 16'hABCD);
    ld(LP, 0, 4'd1, 1, 0, 16'hABCD, 0, 1, "R8 train hit");
    ld(LP, 0, 4'd2, 1, 0, 16'hABCD, 0, 1, "R8 train hit");
    fill(8'h09, 16'h0009); fill(8'h0D, 16'h000D); fill(8'h11, 16'h0011); fill(8'h19, 16'h0019);
    ld(LP, 1, 4'd8, 0, 1, 16'hABCD, 0, 0, "R8 predicted shadowed miss");
    ld(LP, 1, 4'd9, 0, 0, 16'h0000, 0, 0, "R9 second guess blocked");
    ld(LP, 0, 4'd8, 0, 0, 16'h0000, 1, 0, "R10 validation reissue");
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    do_reset();
    // R11 reset state
    chk1("R11 rsp_valid", 32'(rsp_valid), 0);
    chk1("R11 miss_valid", 32'(miss_valid), 0);
    chk1("R11 pf_valid", 32'(pf_valid | pf_rel_valid), 0);
    chk1("R11 mispredict_valid", 32'(mispredict_valid), 0);
    ld(LA, 0, 4'd0, 0, 0, 0, 1, 0, "R11 R2 cold miss");

    // R1 R12: demand hit moves the victim from A to B
    do_reset();
    fill4();
    ld(LA, 0, 4'd1, 1, 0, 16'h1111, 0, 1, "R1 unshadowed hit");
    fill(LE, 16'h5555);
    ld(LB, 1, 4'd2, 0, 0, 0, 0, 0, "R12 R4 B evicted, shadowed miss");
    ld(LA, 1, 4'd3, 1, 0, 16'h1111, 0, 0, "R1 A kept");
    ld(LE, 1, 4'd4, 1, 0, 16'h5555, 0, 0, "R12 E installed");

    // R3: shadowed hit leaves A as victim
    do_reset();
    fill4();
    ld(LA, 1, 4'd4, 1, 0, 16'h1111, 0, 0, "R3 shadowed hit");
    fill(LE, 16'h5555);
    ld(LA, 0, 4'd5, 0, 0, 0, 1, 0, "R3 A evicted");
    ld(LB, 1, 4'd6, 1, 0, 16'h2222, 0, 0, "R3 B kept");

    // R5: release applies the held update
    do_reset();
    fill4();
    ld(LA, 1, 4'd6, 1, 0, 16'h1111, 0, 0, "R5 shadowed hit");
    rel(4'd9, 0, 0, "R5 unknown index");
    rel(4'd6, 1, LA, "R5 matching index");
    rel(4'd6, 0, 0, "R5 second release");
    fill(LE, 16'h5555);
    ld(LB, 1, 4'd7, 0, 0, 0, 0, 0, "R5 B evicted after release");
    ld(LA, 1, 4'd8, 1, 0, 16'h1111, 0, 0, "R5 A kept");

    // R6: squash drops younger entries only
    do_reset();
    fill4();
    ld(LA, 1, 4'd7, 1, 0, 16'h1111, 0, 0, "R6 young parked");
    ld(LC, 1, 4'd2, 1, 0, 16'h3333, 0, 0, "R6 old parked");
    squash(4'd4);
    rel(4'd7, 0, 0, "R6 squashed entry");
    rel(4'd2, 1, LC, "R6 surviving entry");
    fill(LE, 16'h5555);
    ld(LB, 1, 4'd3, 0, 0, 0, 0, 0, "R6 B evicted after C release");

    // R7: buffer full
    do_reset();
    fill(LA, 16'h1111);
    for (int i = 1; i <= 4; i++)
      ld(LA, 1, LW'(i), 1, 0, 16'h1111, 0, 0, "R7 filling buffer");
    ld(LA, 1, 4'd5, 0, 0, 0, 0, 0, "R7 full buffer hit degrades");
    rel(4'd1, 1, LA, "R7 release frees slot");
    ld(LA, 1, 4'd6, 1, 0, 16'h1111, 0, 0, "R7 slot reused");

    // R8 R9 R10: correct guess
    do_reset();
    vp_setup();
    fill(LP, 16'hABCD);
    chk1("R10 matching fill no flag", 32'(mispredict_valid), 0);

    // R10: wrong guess
    do_reset();
    vp_setup();
    fill(LP, 16'h1234);
    chk1("R10 mismatch flag", 32'(mispredict_valid), 1);
    chk1("R10 mismatch index", 32'(mispredict_lqid), 32'd8);
    @(negedge clk);
    chk1("R10 flag is one pulse", 32'(mispredict_valid), 0);

    repeat (3) @(negedge clk);
    chk1("R1 all responses seen", 32'(exp_q.size()), 0);
    finish_run();
  end
endmodule